// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block runs ahead of the instruction decoder. It holds a linear fetch pointer and asks the bus controller for the next aligned dword of code whenever the controller has no execution data cycle to run. Each returned dword goes into a byte-granular ring of code bytes. The decoder sees the oldest bytes of that ring in a small window and removes between zero and four of them per cycle.

A taken jump drives a one-cycle flush together with the new target address. The flush empties the ring and aims the fetch pointer at the dword that holds the target. If a fetch is already in flight, its data is thrown away when it arrives. When the target is not dword-aligned, the bytes in front of it in the first returned dword never enter the ring. The fetch address is linear: the block does no segment or page translation.

Only one fetch is outstanding at a time. A request is raised only when the ring has room for a whole dword, so a granted fetch always fits when its data returns.

Top module: `code_prefetch_queue`

## Requirements
- R1: While reset is asserted and on leaving reset, the ring is empty (`dec_avail_o` = 0), every window lane reads 0x00, and `fetch_addr_o` equals `RESET_PC` with its two low bits cleared.
- R2: `fetch_req_o` is low while `bus_exec_busy_i` is high, while `flush_i` is high, and while a granted fetch has not yet returned its data.
- R3: Each grant (`fetch_req_o` and `fetch_gnt_i` both high on a clock edge) advances `fetch_addr_o` by 4. The address wraps modulo 2^32, and its two low bits are always 0.
- R4: A returned dword is stored little-endian. Bits [7:0] hold the byte at the fetch address, and bits [8k+7:8k] hold the byte at address + k.
- R5: Lane k of `dec_bytes_o` (bits [8k+7:8k], k = 0..3) holds the k-th oldest queued byte. It reads 0x00 when k ≥ `dec_avail_o`. A pop of n bytes (0..4, never more than `dec_avail_o`) removes the n oldest bytes at the clock edge.
- R6: The ring holds at most 16 bytes. A fetch is requested only while `dec_avail_o` ≤ 12. With the bus idle and no pops, the ring fills to 16 and then stops requesting.
- R7: A cycle with `flush_i` high gives `dec_avail_o` = 0 in the following cycle. The next requested address is `flush_target_i` with bits [1:0] cleared. Pops in the flush cycle are ignored.
- R8: If a fetch is outstanding when a flush arrives, its data is discarded when it returns. No new request is made before that data returns.
- R9: For the first fetch after a flush, the first `flush_target_i[1:0]` bytes of the returned dword are dropped. Only 4 − `flush_target_i[1:0]` bytes are added, and the oldest of them is the byte at the target address.
- R10: When a returned dword and a pop meet on the same edge, the count becomes old count + bytes written − bytes popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Taken jump: flush the ring and redirect fetching |
| flush_target_i | input | 32 | Linear address of the jump target |
| bus_exec_busy_i | input | 1 | Bus is reserved for execution data cycles |
| fetch_req_o | output | 1 | Code fetch request |
| fetch_addr_o | output | 32 | Dword-aligned code fetch address |
| fetch_gnt_i | input | 1 | Bus controller accepts the request this cycle |
| fetch_rvalid_i | input | 1 | Fetched dword is present on `fetch_rdata_i` |
| fetch_rdata_i | input | 32 | Fetched dword, little-endian |
| dec_avail_o | output | 5 | Number of queued bytes (0..16) |
| dec_bytes_o | output | 32 | Four oldest queued bytes, oldest in [7:0] |
| dec_pop_i | input | 3 | Bytes consumed by the decoder this cycle (0..4) |

## Verification
The bench uses the default 16-byte ring, the 4-byte bus and the 4-byte decode window, and overrides `RESET_PC` to 0xFFFF_FFF8. With that setting the very first fill crosses the top of the address space after two fetches, so address wrap and the byte order across the wrap are checked without a separate test. A variable response latency of 0 to 6 cycles makes it possible to flush while a fetch is outstanding, and flush targets with every low-bit offset, including one just below the wrap point, cover leading-byte discard together with wrap.

// File: rtl/cpq_pkg.sv
package cpq_pkg;

    // Fetch sequencer: idle, waiting on a live fetch, or waiting on a
    // fetch whose data must be thrown away because a flush overtook it.
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_DROP = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/cpq_fetch_ctl.sv
module cpq_fetch_ctl
    import cpq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    localparam int LANE_W   = $clog2(BUS_BYTES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              busy_i,
    input  logic              room_i,
    input  logic              gnt_i,
    input  logic              rvalid_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [LANE_W-1:0] wr_first_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        fetch_state_e      st;
        logic [LANE_W-1:0] skip;
    } fctl_t;

    localparam fctl_t FCTL_RST = '{
        ptr:  {RESET_PC[ADDR_W-1:LANE_W], LANE_W'(0)},
        st:   FS_IDLE,
        skip: RESET_PC[LANE_W-1:0]
    };

    fctl_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        req_o   = (s_q.st == FS_IDLE) && !busy_i && !flush_i && room_i;
        wr_en_o = rvalid_i && (s_q.st == FS_WAIT) && !flush_i;

        if (req_o && gnt_i) begin
            s_d.ptr = s_q.ptr + ADDR_W'(BUS_BYTES);
            s_d.st  = FS_WAIT;
        end
        if (rvalid_i && (s_q.st != FS_IDLE)) begin
            s_d.st = FS_IDLE;
        end
        if (wr_en_o) begin
            s_d.skip = '0;
        end
        if (flush_i) begin
            s_d.ptr  = {target_i[ADDR_W-1:LANE_W], LANE_W'(0)};
            s_d.skip = target_i[LANE_W-1:0];
            if ((s_q.st == FS_WAIT) && !rvalid_i) begin
                s_d.st = FS_DROP;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= FCTL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_o     = s_q.ptr;
    assign wr_first_o = s_q.skip;

    // A granted fetch blocks the next request (R2).
    p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && gnt_i) |=> !req_o);

    // A grant steps the address by one bus word (R3).
    p_seq_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && gnt_i) |=> (addr_o == $past(addr_o) + ADDR_W'(BUS_BYTES)));

    // A flush points the next fetch at the word holding the target (R7).
    p_redirect_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (addr_o == {$past(target_i[ADDR_W-1:LANE_W]), LANE_W'(0)}));

    // While a stale fetch is pending, nothing is written and nothing is asked for (R8).
    p_drop_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == FS_DROP) |-> (!wr_en_o && !req_o));

endmodule

// File: rtl/cpq_byte_ring.sv
module cpq_byte_ring #(
    parameter int DEPTH     = 16,
    parameter int BUS_BYTES = 4,
    parameter int POP_MAX   = 4,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int LANE_W   = $clog2(BUS_BYTES),
    localparam int POP_W    = $clog2(POP_MAX + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   flush_i,
    input  logic                   wr_en_i,
    input  logic [LANE_W-1:0]      wr_first_i,
    input  logic [8*BUS_BYTES-1:0] wr_data_i,
    input  logic [POP_W-1:0]       pop_i,
    output logic [CNT_W-1:0]       count_o,
    output logic [8*POP_MAX-1:0]   window_o
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [IDX_W-1:0]      rd;
        logic [IDX_W-1:0]      wr;
        logic [CNT_W-1:0]      cnt;
    } ring_t;

    ring_t            s_d, s_q;
    logic [CNT_W-1:0] n_wr;

    always_comb begin
        s_d  = s_q;
        n_wr = '0;
        if (flush_i) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (wr_en_i) begin
                n_wr = CNT_W'(BUS_BYTES) - CNT_W'(wr_first_i);
                for (int l = 0; l < BUS_BYTES; l++) begin
                    if (LANE_W'(l) >= wr_first_i) begin
                        s_d.mem[s_q.wr + IDX_W'(l) - IDX_W'(wr_first_i)] = wr_data_i[8*l +: 8];
                    end
                end
                s_d.wr = s_q.wr + IDX_W'(n_wr);
            end
            s_d.rd  = s_q.rd + IDX_W'(pop_i);
            s_d.cnt = s_q.cnt + n_wr - CNT_W'(pop_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar k = 0; k < POP_MAX; k++) begin : g_win
        logic [IDX_W-1:0] pos;
        assign pos = s_q.rd + IDX_W'(k);
        assign window_o[8*k +: 8] = (s_q.cnt > CNT_W'(k)) ? s_q.mem[pos] : 8'h00;
    end

    assign count_o = s_q.cnt;

    // The decoder never removes more than is queued (R5).
    p_pop_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flush_i |-> (CNT_W'(pop_i) <= s_q.cnt));

    // The ring never holds more than its capacity (R6).
    p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
    parameter int ADDR_W    = 32,
    parameter int DEPTH     = 16,
    parameter int BUS_BYTES = 4,
    parameter int POP_MAX   = 4,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'hFFFF_FFF0,
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int LANE_W   = $clog2(BUS_BYTES),
    localparam int POP_W    = $clog2(POP_MAX + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   flush_i,
    input  logic [ADDR_W-1:0]      flush_target_i,
    input  logic                   bus_exec_busy_i,
    output logic                   fetch_req_o,
    output logic [ADDR_W-1:0]      fetch_addr_o,
    input  logic                   fetch_gnt_i,
    input  logic                   fetch_rvalid_i,
    input  logic [8*BUS_BYTES-1:0] fetch_rdata_i,
    output logic [CNT_W-1:0]       dec_avail_o,
    output logic [8*POP_MAX-1:0]   dec_bytes_o,
    input  logic [POP_W-1:0]       dec_pop_i
);

    localparam int ROOM_LIMIT = DEPTH - BUS_BYTES;

    logic              room;
    logic              wr_en;
    logic [LANE_W-1:0] wr_first;

    assign room = (dec_avail_o <= CNT_W'(ROOM_LIMIT));

    cpq_fetch_ctl #(
        .ADDR_W    (ADDR_W),
        .BUS_BYTES (BUS_BYTES),
        .RESET_PC  (RESET_PC)
    ) u_fetch (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (flush_i),
        .target_i   (flush_target_i),
        .busy_i     (bus_exec_busy_i),
        .room_i     (room),
        .gnt_i      (fetch_gnt_i),
        .rvalid_i   (fetch_rvalid_i),
        .req_o      (fetch_req_o),
        .addr_o     (fetch_addr_o),
        .wr_en_o    (wr_en),
        .wr_first_o (wr_first)
    );

    cpq_byte_ring #(
        .DEPTH     (DEPTH),
        .BUS_BYTES (BUS_BYTES),
        .POP_MAX   (POP_MAX)
    ) u_ring (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (flush_i),
        .wr_en_i    (wr_en),
        .wr_first_i (wr_first),
        .wr_data_i  (fetch_rdata_i),
        .pop_i      (dec_pop_i),
        .count_o    (dec_avail_o),
        .window_o   (dec_bytes_o)
    );

    // Execution data cycles own the bus (R2).
    p_busy_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_exec_busy_i |-> !fetch_req_o);

    // Fetch addresses stay word aligned (R3).
    p_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_addr_o[LANE_W-1:0] == '0);

    // A request is made only with room for a full word (R6).
    p_room_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_req_o |-> (dec_avail_o <= CNT_W'(ROOM_LIMIT)));

    // A flush leaves the ring empty in the next cycle (R7).
    p_flush_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (dec_avail_o == '0));

endmodule

// File: tb/code_prefetch_queue_tb.sv
module code_prefetch_queue_tb;

    localparam logic [31:0] TB_RESET_PC = 32'hFFFF_FFF8;

    typedef struct packed {
        logic [31:0] tgt;
        logic [2:0]  sz;
        logic [2:0]  lat;
        logic [4:0]  exp_avail;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 3'd1, 3'd0, 5'd16},
        '{32'h0000_2001, 3'd2, 3'd1, 5'd15},
        '{32'h0000_3002, 3'd3, 3'd2, 5'd14},
        '{32'h0000_4003, 3'd4, 3'd0, 5'd13},
        '{32'hFFFF_FFFE, 3'd2, 3'd1, 5'd14},
        '{32'h1234_5679, 3'd4, 3'd3, 5'd15}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] target = '0;
    logic        busy = 1'b1;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_gnt = 1'b1;
    logic        fetch_rvalid = 1'b0;
    logic [31:0] fetch_rdata = '0;
    logic [4:0]  dec_avail;
    logic [31:0] dec_bytes;
    logic [2:0]  dec_pop = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int lat = 0;

    // bus model state
    bit          m_out = 1'b0;
    int          m_cd = 0;
    logic [31:0] m_addr = '0;
    bit          have_prev = 1'b0;
    logic [31:0] prev_addr = '0;

    always #4 clk = ~clk;

    code_prefetch_queue #(.RESET_PC(TB_RESET_PC)) u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .flush_i         (flush),
        .flush_target_i  (target),
        .bus_exec_busy_i (busy),
        .fetch_req_o     (fetch_req),
        .fetch_addr_o    (fetch_addr),
        .fetch_gnt_i     (fetch_gnt),
        .fetch_rvalid_i  (fetch_rvalid),
        .fetch_rdata_i   (fetch_rdata),
        .dec_avail_o     (dec_avail),
        .dec_bytes_o     (dec_bytes),
        .dec_pop_i       (dec_pop)
    );

    function automatic logic [7:0] bval(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {bval(a + 32'd3), bval(a + 32'd2), bval(a + 32'd1), bval(a)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory-side bus model: grants at once, answers after lat extra cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            fetch_rvalid <= 1'b0;
            m_out = 1'b0;
            have_prev = 1'b0;
        end else begin
            fetch_rvalid <= 1'b0;
            if (flush) have_prev = 1'b0;
            if (m_out) begin
                if (m_cd == 0) begin
                    fetch_rvalid <= 1'b1;
                    fetch_rdata  <= word_at(m_addr);
                    m_out = 1'b0;
                end else begin
                    m_cd = m_cd - 1;
                end
            end
            if (fetch_req && fetch_gnt) begin
                if (have_prev) chk("R3 sequential fetch address", fetch_addr, prev_addr + 32'd4);
                prev_addr = fetch_addr;
                have_prev = 1'b1;
                m_out  = 1'b1;
                m_addr = fetch_addr;
                m_cd   = lat;
            end
        end
    end

    task automatic check_window(input logic [31:0] pc, input int a, input string tag);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] exp;
            exp = (k < a) ? bval(pc + 32'(k)) : 8'h00;
            chk(tag, 32'(dec_bytes[8*k +: 8]), 32'(exp));
        end
    endtask

    // Pops while fetching goes on; checks window contents and R10 accounting.
    task automatic drain(input int n, input int sz, input string tag, inout logic [31:0] pc);
        int pa = 0;
        int ppop = 0;
        bit pr = 1'b0;
        for (int i = 0; i < n; i++) begin
            int a;
            int p;
            bit r;
            @(negedge clk);
            a = int'(dec_avail);
            r = fetch_rvalid;
            if (i > 0) chk("R10 fill and pop count", 32'(a), 32'(pa - ppop + (pr ? 4 : 0)));
            check_window(pc, a, tag);
            p = (sz == 0) ? (i % 4) + 1 : sz;
            if (p > a) p = a;
            dec_pop = 3'(p);
            pc = pc + 32'(p);
            pa = a;
            pr = r;
            ppop = p;
        end
        @(negedge clk);
        dec_pop = '0;
    endtask

    initial begin
        logic [31:0] pc;
        repeat (3) @(negedge clk);
        chk("R1 avail in reset", 32'(dec_avail), 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1 avail after reset", 32'(dec_avail), 32'd0);
        chk("R1 window after reset", dec_bytes, 32'd0);
        chk("R1 start address", fetch_addr, TB_RESET_PC);
        repeat (3) @(negedge clk);
        chk("R2 no request while busy", 32'(fetch_req), 32'd0);
        chk("R2 nothing fetched while busy", 32'(dec_avail), 32'd0);

        // fill from reset: crosses the top of the address space
        busy = 1'b0;
        repeat (40) @(negedge clk);
        chk("R6 ring full", 32'(dec_avail), 32'd16);
        chk("R6 no request when full", 32'(fetch_req), 32'd0);
        check_window(TB_RESET_PC, 16, "R4 byte order after fill");
        pc = TB_RESET_PC;
        drain(24, 0, "R5 window while draining across wrap", pc);

        // table of flush targets, pop sizes and latencies
        for (int v = 0; v < NVEC; v++) begin
            busy = 1'b1;
            lat = int'(VECS[v].lat);
            repeat (8) @(negedge clk);
            flush = 1'b1;
            target = VECS[v].tgt;
            dec_pop = 3'd1;
            #1;
            chk("R2 no request during flush", 32'(fetch_req), 32'd0);
            @(negedge clk);
            flush = 1'b0;
            dec_pop = '0;
            chk("R7 ring empty after flush", 32'(dec_avail), 32'd0);
            chk("R7 redirected address", fetch_addr, {VECS[v].tgt[31:2], 2'b00});
            busy = 1'b0;
            repeat (40) @(negedge clk);
            chk("R9 count after unaligned start", 32'(dec_avail), 32'(VECS[v].exp_avail));
            check_window(VECS[v].tgt, int'(VECS[v].exp_avail), "R9 first byte is target");
            pc = VECS[v].tgt;
            drain(16, int'(VECS[v].sz), "R5 window after flush", pc);
        end

        // flush overtaking an outstanding fetch
        busy = 1'b1;
        lat = 6;
        repeat (10) @(negedge clk);
        flush = 1'b1;
        target = 32'h0000_5000;
        @(negedge clk);
        flush = 1'b0;
        busy = 1'b0;
        while (!m_out) @(negedge clk);
        flush = 1'b1;
        target = 32'h0000_6002;
        @(negedge clk);
        flush = 1'b0;
        chk("R8 no request while stale fetch pending", 32'(fetch_req), 32'd0);
        chk("R8 ring empty", 32'(dec_avail), 32'd0);
        repeat (3) @(negedge clk);
        chk("R2 still one fetch outstanding", 32'(fetch_req), 32'd0);
        lat = 0;
        repeat (60) @(negedge clk);
        chk("R8 stale data discarded", 32'(dec_avail), 32'd14);
        check_window(32'h0000_6002, 14, "R8 only new target bytes");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule